// File: doc/BRIEF.md
# Sectioned Radix-4 Recoded Multiplier

A pipelined signed integer multiplier. Two 18-bit two's-complement operands go in, and their exact 36-bit product comes out. A new operand pair can be accepted on every clock, and results leave in the order they entered. The multiplier operand is recoded into signed radix-4 digits, so each digit selects zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. A product is formed from these partial products in carry-save form.

The reduction is not one deep combinational tree. It is cut into pipeline sections, and each section absorbs a fixed slice of the recoded digits into a running sum/carry pair. With the default parameters there are nine digits, three per section, over three sections. A last registered carry-propagate add resolves the pair. A valid flag travels with each operand pair. A result appears a fixed four cycles after its operands.

Top module: `radix4_sectioned_mul`

## Requirements
- R1: When `valid_o` is high, `prod_o` equals the signed product of the `a_i` and `b_i` sampled four rising edges earlier, as a 36-bit two's-complement value.
- R2: `valid_o` is high on exactly the fourth rising edge after a rising edge that samples `valid_i` high; the latency does not depend on operand values.
- R3: A new pair may be presented on every cycle; back-to-back pairs produce back-to-back results in input order.
- R4: While `rst_ni` is low and on the first four edges after its release, `valid_o` is low.
- R5: Digit j of the multiplier is formed from bits b[2j+1], b[2j], b[2j-1] (b[-1] taken as 0) as -2·b[2j+1] + b[2j] + b[2j-1], which is a value in {-2,-1,0,+1,+2}. Multipliers chosen so that their digits take every one of these values still give the exact product.
- R6: Extreme operands give exact results: (-2^17)·(-2^17) = 2^34, (-2^17)·(2^17-1), (2^17-1)·(2^17-1), and any operand times -1 or 0.
- R7: A cycle with `valid_i` low yields a cycle with `valid_o` low four edges later, and it does not disturb the results of its neighbours.
- R8: Pulling `rst_ni` low in the middle of a stream drops every pair in flight at once, so that `valid_o` goes low without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair on a_i/b_i is valid this cycle |
| a_i | input | 18 | Multiplicand, two's complement |
| b_i | input | 18 | Multiplier, two's complement, radix-4 recoded |
| valid_o | output | 1 | prod_o carries a result this cycle |
| prod_o | output | 36 | Double-length signed product |

## Verification
The assertions assume that `valid_i`, `a_i` and `b_i` are known, 0 or 1, on every rising edge after reset. They also assume that `valid_i` is held low while reset is active, because the checker's own history of inputs is cleared together with the pipeline. The stimulus drives every input at the falling clock edge from a fixed value, and it lowers `valid_i` before it asserts reset, both at start-up and in the middle of the run. The bench's behavioural model predicts both `valid_o` and `prod_o` on every cycle. The stimulus mixes a table of extreme operands and digit patterns, long back-to-back bursts, and random streams with bubbles.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } booth_digit_t;

  // t = {b[2j+1], b[2j], b[2j-1]}
  function automatic logic booth_neg(input logic [2:0] t);
    return t[2] & ~(t[1] & t[0]);
  endfunction

  function automatic booth_digit_t booth_decode(input logic [2:0] t);
    booth_digit_t d;
    d.one = t[1] ^ t[0];
    d.two = (t[2] & ~t[1] & ~t[0]) | (~t[2] & t[1] & t[0]);
    d.neg = booth_neg(t);
    return d;
  endfunction

endpackage

// File: rtl/mul_csa32.sv
module mul_csa32 #(
  parameter int PW = 36
) (
  input  logic [PW-1:0] x_i,
  input  logic [PW-1:0] y_i,
  input  logic [PW-1:0] z_i,
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] carry_o
);
  logic [PW-2:0] maj;

  assign sum_o   = x_i ^ y_i ^ z_i;
  assign maj     = (x_i[PW-2:0] & y_i[PW-2:0]) |
                   (x_i[PW-2:0] & z_i[PW-2:0]) |
                   (y_i[PW-2:0] & z_i[PW-2:0]);
  assign carry_o = {maj, 1'b0};
endmodule

// File: rtl/mul_booth_pp.sv
module mul_booth_pp
  import mul_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter int PW    = 36,
  parameter int IDX   = 0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [2:0]       cur_i,
  input  logic [2:0]       prev_i,
  output logic [PW-1:0]    pp_o
);
  localparam int SH = 2 * IDX;
  // correction of digit IDX-1 rides in the empty low bits of this row;
  // digit -1 is always zero, so bit 0 is harmless for IDX 0
  localparam int CP = (IDX == 0) ? 0 : SH - 2;

  booth_digit_t dig;
  logic [PW-1:0] a_ext, mag, flip, corr;

  assign dig   = booth_decode(cur_i);
  assign a_ext = PW'($signed(a_i));

  always_comb begin
    if (dig.two)      mag = {a_ext[PW-2:0], 1'b0};
    else if (dig.one) mag = a_ext;
    else              mag = '0;
  end

  assign flip = mag ^ {PW{dig.neg}};
  assign corr = {{(PW-1){1'b0}}, booth_neg(prev_i)} << CP;
  assign pp_o = (flip << SH) | corr;
endmodule

// File: rtl/mul_csa_section.sv
module mul_csa_section #(
  parameter int WIDTH = 18,
  parameter int PW    = 36,
  parameter int DPS   = 3,
  parameter int FIRST = 0
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [2*DPS+2:0]   win_i,
  input  logic [PW-1:0]      sum_i,
  input  logic [PW-1:0]      carry_i,
  output logic [PW-1:0]      sum_o,
  output logic [PW-1:0]      carry_o
);
  logic [DPS-1:0][PW-1:0] pp;

  for (genvar k = 0; k < DPS; k++) begin : g_pp
    mul_booth_pp #(
      .WIDTH (WIDTH),
      .PW    (PW),
      .IDX   (FIRST + k)
    ) u_pp (
      .a_i    (a_i),
      .cur_i  (win_i[2*k+4 -: 3]),
      .prev_i (win_i[2*k+2 -: 3]),
      .pp_o   (pp[k])
    );
  end

  if (DPS == 3) begin : g_tree
    // three rows, then the incoming pair: 5 -> 4 -> 3 -> 2
    logic [PW-1:0] l1_s, l1_c, l2_s, l2_c;

    mul_csa32 #(.PW(PW)) u_l1 (
      .x_i(pp[0]), .y_i(pp[1]), .z_i(pp[2]),
      .sum_o(l1_s), .carry_o(l1_c)
    );
    mul_csa32 #(.PW(PW)) u_l2 (
      .x_i(l1_s), .y_i(l1_c), .z_i(sum_i),
      .sum_o(l2_s), .carry_o(l2_c)
    );
    mul_csa32 #(.PW(PW)) u_l3 (
      .x_i(l2_s), .y_i(l2_c), .z_i(carry_i),
      .sum_o(sum_o), .carry_o(carry_o)
    );
  end else begin : g_chain
    logic [DPS:0][PW-1:0] cs, cc;

    assign cs[0] = sum_i;
    assign cc[0] = carry_i;
    for (genvar k = 0; k < DPS; k++) begin : g_lvl
      mul_csa32 #(.PW(PW)) u_csa (
        .x_i(cs[k]), .y_i(cc[k]), .z_i(pp[k]),
        .sum_o(cs[k+1]), .carry_o(cc[k+1])
      );
    end
    assign sum_o   = cs[DPS];
    assign carry_o = cc[DPS];
  end
endmodule

// File: rtl/radix4_sectioned_mul.sv
module radix4_sectioned_mul
  import mul_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter int DPS   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic               valid_o,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int PW   = 2 * WIDTH;
  localparam int NDIG = (WIDTH + 1) / 2;
  localparam int NSEC = (NDIG + DPS - 1) / DPS;
  localparam int NTOT = NSEC * DPS;
  localparam int YEP  = 2 * NTOT + 1;

  // multiplier sign-extended to the padded digit count, with b[-1] = 0 below
  logic signed [YEP-2:0] b_sx;
  logic [YEP-1:0]        ye0;
  logic [PW-1:0]         corr_init;

  assign b_sx      = (YEP-1)'($signed(b_i));
  assign ye0       = {b_sx, 1'b0};
  // the top digit has no row above it to carry its correction bit
  assign corr_init = {{(PW-1){1'b0}}, booth_neg(ye0[YEP-1 -: 3])} << (2 * (NTOT - 1));

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    localparam int BASE = (s == 0) ? 0 : 2 * s * DPS - 2;
    localparam int YW   = YEP - BASE;

    logic             vin;
    logic [WIDTH-1:0] ain;
    logic [YW-1:0]    yin;
    logic [PW-1:0]    sin, cin;
    logic [2*DPS+2:0] win;
    logic [PW-1:0]    sum_d, car_d;
    logic             v_q;
    logic [PW-1:0]    s_q, c_q;

    if (s == 0) begin : g_head
      assign vin = valid_i;
      assign ain = a_i;
      assign yin = ye0;
      assign sin = '0;
      assign cin = corr_init;
      assign win = {yin[2*DPS:0], 2'b00};
    end else begin : g_body
      assign vin = g_sec[s-1].v_q;
      assign ain = g_sec[s-1].g_fwd.a_q;
      assign yin = g_sec[s-1].g_fwd.y_q;
      assign sin = g_sec[s-1].s_q;
      assign cin = g_sec[s-1].c_q;
      assign win = yin[2*DPS+2:0];
    end

    mul_csa_section #(
      .WIDTH (WIDTH),
      .PW    (PW),
      .DPS   (DPS),
      .FIRST (s * DPS)
    ) u_section (
      .a_i     (ain),
      .win_i   (win),
      .sum_i   (sin),
      .carry_i (cin),
      .sum_o   (sum_d),
      .carry_o (car_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        s_q <= '0;
        c_q <= '0;
      end else begin
        v_q <= vin;
        s_q <= sum_d;
        c_q <= car_d;
      end
    end

    if (s < NSEC - 1) begin : g_fwd
      // keep only the multiplier bits later sections still read
      localparam int STEP = (s == 0) ? 2 * DPS - 2 : 2 * DPS;
      logic [WIDTH-1:0]   a_q;
      logic [YW-STEP-1:0] y_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          a_q <= '0;
          y_q <= '0;
        end else begin
          a_q <= ain;
          y_q <= yin[YW-1:STEP];
        end
      end
    end
  end

  logic          v_out;
  logic [PW-1:0] p_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_out <= 1'b0;
      p_out <= '0;
    end else begin
      v_out <= g_sec[NSEC-1].v_q;
      p_out <= g_sec[NSEC-1].s_q + g_sec[NSEC-1].c_q;
    end
  end

  assign valid_o = v_out;
  assign prod_o  = p_out;
endmodule

// File: rtl/radix4_sectioned_mul_chk.sv
module radix4_sectioned_mul_chk #(
  parameter int WIDTH = 18,
  parameter int LAT   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               valid_o,
  input logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;

  logic [LAT-1:0]   hv;
  logic [WIDTH-1:0] ha [LAT];
  logic [WIDTH-1:0] hb [LAT];
  logic [PW-1:0]    expect_p;
  logic [WIDTH-1:0] min_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv <= '0;
      for (int i = 0; i < LAT; i++) begin
        ha[i] <= '0;
        hb[i] <= '0;
      end
    end else begin
      hv <= {hv[LAT-2:0], valid_i};
      ha[0] <= a_i;
      hb[0] <= b_i;
      for (int i = 1; i < LAT; i++) begin
        ha[i] <= ha[i-1];
        hb[i] <= hb[i-1];
      end
    end
  end

  assign expect_p = PW'($signed(ha[LAT-1])) * PW'($signed(hb[LAT-1]));
  assign min_val  = {1'b1, {(WIDTH-1){1'b0}}};

  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == hv[LAT-1]);

  a_r1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> prod_o == expect_p);

  a_r6_min_squared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ha[LAT-1] == min_val && hb[LAT-1] == min_val)
      |-> prod_o == ({{(PW-1){1'b0}}, 1'b1} << (PW - 2)));

  a_r3_valid_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(valid_o));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r4_idle_in_reset: assert (!valid_o);
    end
  end
endmodule

bind radix4_sectioned_mul radix4_sectioned_mul_chk #(
  .WIDTH (WIDTH),
  .LAT   (NSEC + 1)
) u_chk (.*);

// File: tb/tb_radix4_sectioned_mul.sv
module tb_radix4_sectioned_mul;
  localparam int W   = 18;
  localparam int PW  = 36;
  localparam int LAT = 4;
  localparam logic [W-1:0] MINV = 18'h20000;
  localparam logic [W-1:0] MAXV = 18'h1FFFF;
  localparam logic [W-1:0] NEG1 = 18'h3FFFF;

  logic          clk_i   = 1'b0;
  logic          rst_ni  = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  a_i     = '0;
  logic [W-1:0]  b_i     = '0;
  logic          valid_o;
  logic [PW-1:0] prod_o;

  always #2 clk_i = ~clk_i;

  radix4_sectioned_mul dut (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i, .valid_o, .prod_o
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit            q_v[$];
  logic [PW-1:0] q_p[$];
  string         q_t[$];

  function automatic logic [PW-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return PW'(sa * sb);
  endfunction

  task automatic check(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic refill();
    q_v.delete(); q_p.delete(); q_t.delete();
    for (int i = 0; i < LAT; i++) begin
      q_v.push_back(1'b0); q_p.push_back('0); q_t.push_back("R4");
    end
  endtask

  // one cycle: check what leaves now, then present the next pair
  task automatic step(bit v, logic [W-1:0] a, logic [W-1:0] b, string tag);
    bit            ev;
    logic [PW-1:0] ep;
    string         et;
    @(negedge clk_i);
    ev = q_v.pop_front();
    ep = q_p.pop_front();
    et = q_t.pop_front();
    check({et, " valid"}, PW'(valid_o), PW'(ev));
    if (ev) check({et, " product"}, prod_o, ep);
    valid_i = v;
    a_i     = a;
    b_i     = b;
    q_v.push_back(v);
    q_p.push_back(ref_mul(a, b));
    q_t.push_back(v ? tag : "R7");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R4: quiet during reset and just after release
    repeat (3) @(negedge clk_i);
    check("R4 in reset", PW'(valid_o), '0);
    refill();
    rst_ni = 1'b1;

    // R2: one isolated pair, exact latency
    step(1'b1, 18'd3, 18'd5, "R2");
    idle(LAT + 1);

    // R6: extremes, back to back
    step(1'b1, MINV, MINV, "R6");
    step(1'b1, MINV, MAXV, "R6");
    step(1'b1, MAXV, MINV, "R6");
    step(1'b1, MAXV, MAXV, "R6");
    step(1'b1, MINV, NEG1, "R6");
    step(1'b1, NEG1, NEG1, "R6");
    step(1'b1, MAXV, NEG1, "R6");
    step(1'b1, MINV, '0,   "R6");
    step(1'b1, '0,   MAXV, "R6");

    // R5: multipliers whose digits cover -2..+2
    step(1'b1, 18'h12345, 18'h00001, "R5");
    step(1'b1, 18'h12345, 18'h00002, "R5");
    step(1'b1, 18'h12345, 18'h00003, "R5");
    step(1'b1, 18'h2ABCD, 18'h15555, "R5");
    step(1'b1, 18'h2ABCD, 18'h2AAAA, "R5");
    step(1'b1, 18'h0F0F0, 18'h33333, "R5");
    step(1'b1, 18'h3FFFE, 18'h0CCCC, "R5");
    step(1'b1, 18'h1FFFF, 18'h24924, "R5");
    for (int j = 0; j < W; j++) step(1'b1, 18'h2D2D2, W'(1) << j, "R5");
    idle(LAT);

    // R3: long back-to-back burst
    for (int i = 0; i < 600; i++) step(1'b1, W'($urandom), W'($urandom), "R3");

    // R1/R7: random stream with bubbles
    for (int i = 0; i < 1500; i++)
      step(($urandom % 10) < 7, W'($urandom), W'($urandom), "R1");

    // R8: reset with pairs in flight
    for (int i = 0; i < LAT; i++) step(1'b1, W'($urandom), W'($urandom), "R8");
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    #1;
    check("R8 flush", PW'(valid_o), '0);
    repeat (2) @(negedge clk_i);
    check("R8 held", PW'(valid_o), '0);
    refill();
    rst_ni = 1'b1;
    idle(LAT + 1);
    for (int i = 0; i < 200; i++)
      step(($urandom % 4) != 0, W'($urandom), W'($urandom), "R1");
    idle(LAT + 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule